// File: doc/BRIEF.md
# Zero-Cross Gated Volume Updater

This block sits in the input path of a stereo audio chain. It keeps the left and right input-volume settings written over a simple register port. It lets each internal 8-bit gain code take a newly written value only at a signal zero crossing on that channel, or when a selectable timeout of sample periods runs out. Deferring the change this way keeps gain steps from producing audible clicks. Rewriting the value already held changes nothing, and in particular leaves a running timeout alone.

An automatic level control loop outside the block can take over the gains. When its enable rises, both channels first move to the left register value through the same zero-cross or timeout gating. After that, the gains requested by the loop are applied once every recovery-wait period. Register writes made while the loop owns the gains are stored but not applied. When the enable falls, each channel moves to its last written value through the usual gating.

Top module: `zcv_volume_ctrl`

## Requirements
- R1: After reset both internal gains and both volume registers hold 0x91, nothing is pending and level control is idle.
- R2: With level control off, a write to address 0x09 (left) or 0x0C (right) whose data differs from that register's value stages the data. The channel's gain takes it at the clock edge of the next zero-crossing sample on that channel, or at the edge of the timeout-th valid sample after the write, whichever comes first.
- R3: A write whose data equals the register's current value has no effect, and a timeout that is already running carries on without restarting.
- R4: A differing write to either register restarts the shared timeout, so differing writes spaced closer than the timeout keep the gain unchanged.
- R5: A valid sample is a zero crossing when its sign bit (bit 15) differs from that of the channel's previous valid sample, or when it equals zero. Each channel uses only its own samples, and the previous sign is positive after reset.
- R6: The timeout select picks 128, 256, 512 or 1024 valid samples for codes 0, 1, 2 and 3. Writes to other addresses are ignored.
- R7: While level control is enabled, volume writes never change a gain. They only update the stored register value.
- R8: When level control becomes enabled, both channels stage the left register value. Each gain takes it at its own zero crossing or at the timeout.
- R9: Once both seeded gains are applied, the requested level gains are loaded every wait-period valid samples. The wait select picks 32, 64, 128 or 256 for codes 0 to 3. The first load comes no later than timeout plus wait samples after the enable.
- R10: When level control is disabled, each channel stages its last written register value and takes it at the next zero crossing or timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| smp_valid | input | 1 | One sample period elapsed; samples valid |
| smp_l | input | 16 | Left signed sample |
| smp_r | input | 16 | Right signed sample |
| lvl_en | input | 1 | Automatic level control enable |
| lvl_gain_l | input | 8 | Gain code requested by level control, left |
| lvl_gain_r | input | 8 | Gain code requested by level control, right |
| tmo_sel | input | 2 | Timeout length select |
| wait_sel | input | 2 | Recovery wait length select |
| gain_l | output | 8 | Internal left gain code |
| gain_r | output | 8 | Internal right gain code |

## Verification
The bench aims at the exact timeout edge, checking the sample just before and the one at which the gain moves. A counter that is off by one would update a sample early or late. A second repeated write mid-timeout is sent to catch a design that restarts the counter on equal data and so updates late. A changed write is sent mid-timeout to catch one that keeps counting and updates early. Handover into and out of level control checks that the right channel is seeded from the left, that frozen writes do not leak into the gains, and that a release replays the last stored values. A leak would show as a gain change during the wait window. Random writes and sign patterns are compared each cycle against a bench model to expose cross-channel use of the zero-crossing detectors.

// File: rtl/zcv_pkg.sv
package zcv_pkg;

  typedef enum logic [1:0] {
    ZCV_MANUAL = 2'd0,
    ZCV_SEED   = 2'd1,
    ZCV_ACTIVE = 2'd2
  } zcv_mode_e;

  // Zero crossing: sign change against the previous sample, or an exact zero.
  function automatic logic zc_check(input logic prev_neg, input logic cur_neg,
                                    input logic cur_zero);
    return cur_zero || (prev_neg != cur_neg);
  endfunction

  // Length picked by a 2-bit select: base, 2*base, 4*base or 8*base.
  function automatic int unsigned sel_limit(input int unsigned base, input logic [1:0] sel);
    return base << sel;
  endfunction

endpackage

// File: rtl/zcv_zero_detect.sv
module zcv_zero_detect #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [DATA_W-1:0] sample,
  output logic              zc
);
  logic prev_neg_q;

  assign zc = tick && zcv_pkg::zc_check(prev_neg_q, sample[DATA_W-1], sample == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    prev_neg_q <= 1'b0;
    else if (tick) prev_neg_q <= sample[DATA_W-1];
  end
endmodule

// File: rtl/zcv_sample_timer.sv
module zcv_sample_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [CW-1:0] limit,
  output logic          hit,
  output logic [CW-1:0] count
);
  assign hit = run && !clr && tick && (count == limit - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           count <= '0;
    else if (clr || !run) count <= '0;
    else if (tick)        count <= hit ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/zcv_volume_ctrl.sv
module zcv_volume_ctrl #(
  parameter int              DATA_W    = 16,
  parameter int              GAIN_W    = 8,
  parameter int              ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ADDR_L  = 8'h09,
  parameter logic [ADDR_W-1:0] ADDR_R  = 8'h0C,
  parameter logic [GAIN_W-1:0] GAIN_DEF = 8'h91,
  parameter int              TMO_BASE  = 128,
  parameter int              WAIT_BASE = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [GAIN_W-1:0] wr_data,
  input  logic              smp_valid,
  input  logic [DATA_W-1:0] smp_l,
  input  logic [DATA_W-1:0] smp_r,
  input  logic              lvl_en,
  input  logic [GAIN_W-1:0] lvl_gain_l,
  input  logic [GAIN_W-1:0] lvl_gain_r,
  input  logic [1:0]        tmo_sel,
  input  logic [1:0]        wait_sel,
  output logic [GAIN_W-1:0] gain_l,
  output logic [GAIN_W-1:0] gain_r
);
  import zcv_pkg::*;

  localparam int NCH = 2;
  localparam int TCW = $clog2(TMO_BASE * 8) + 1;
  localparam int WCW = $clog2(WAIT_BASE * 8) + 1;

  zcv_mode_e mode_q;
  logic [NCH-1:0][GAIN_W-1:0] vol_q, vol_nxt, tgt_q, gain_q, lvl_gain_v;
  logic [NCH-1:0][DATA_W-1:0] smp_v;
  logic [NCH-1:0] pend_q, zc_evt, wr_hit, diff_wr, app;

  logic manual_open, start_evt, release_evt, seed_run, active_run, restart;
  logic tmo_hit, wait_hit;
  logic [TCW-1:0] tmo_lim, tmo_cnt;
  logic [WCW-1:0] wait_lim, wait_cnt;

  assign smp_v      = {smp_r, smp_l};
  assign lvl_gain_v = {lvl_gain_r, lvl_gain_l};
  assign gain_l     = gain_q[0];
  assign gain_r     = gain_q[1];

  // Mode events
  assign manual_open = (mode_q == ZCV_MANUAL) && !lvl_en;
  assign start_evt   = (mode_q == ZCV_MANUAL) && lvl_en;
  assign release_evt = (mode_q != ZCV_MANUAL) && !lvl_en;
  assign seed_run    = (mode_q == ZCV_SEED) && lvl_en;
  assign active_run  = (mode_q == ZCV_ACTIVE) && lvl_en;

  assign tmo_lim  = TCW'(sel_limit(TMO_BASE, tmo_sel));
  assign wait_lim = WCW'(sel_limit(WAIT_BASE, wait_sel));

  // Per-channel zero detectors and write decode
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    localparam logic [ADDR_W-1:0] CH_ADDR = (ch == 0) ? ADDR_L : ADDR_R;

    zcv_zero_detect #(.DATA_W(DATA_W)) u_zc (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (smp_valid),
      .sample (smp_v[ch]),
      .zc     (zc_evt[ch])
    );

    assign wr_hit[ch]  = wr_en && (wr_addr == CH_ADDR);
    assign vol_nxt[ch] = wr_hit[ch] ? wr_data : vol_q[ch];
    assign diff_wr[ch] = manual_open && wr_hit[ch] && (wr_data != vol_q[ch]);
    assign app[ch]     = pend_q[ch] && (zc_evt[ch] || tmo_hit) && !diff_wr[ch]
                         && (manual_open || seed_run);
  end

  assign restart = (|diff_wr) || start_evt || release_evt;

  zcv_sample_timer #(.CW(TCW)) u_tmo (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (restart),
    .run   (|pend_q),
    .tick  (smp_valid),
    .limit (tmo_lim),
    .hit   (tmo_hit),
    .count (tmo_cnt)
  );

  zcv_sample_timer #(.CW(WCW)) u_wait (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!active_run),
    .run   (active_run),
    .tick  (smp_valid),
    .limit (wait_lim),
    .hit   (wait_hit),
    .count (wait_cnt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ZCV_MANUAL;
      vol_q  <= {NCH{GAIN_DEF}};
      tgt_q  <= {NCH{GAIN_DEF}};
      gain_q <= {NCH{GAIN_DEF}};
      pend_q <= '0;
    end else begin
      vol_q <= vol_nxt;
      for (int ch = 0; ch < NCH; ch++) begin
        if (start_evt) begin
          tgt_q[ch]  <= vol_nxt[0];
          pend_q[ch] <= 1'b1;
        end else if (release_evt) begin
          tgt_q[ch]  <= vol_nxt[ch];
          pend_q[ch] <= 1'b1;
        end else if (diff_wr[ch]) begin
          tgt_q[ch]  <= wr_data;
          pend_q[ch] <= 1'b1;
        end else if (app[ch]) begin
          gain_q[ch] <= tgt_q[ch];
          pend_q[ch] <= 1'b0;
        end else if (active_run && wait_hit) begin
          gain_q[ch] <= lvl_gain_v[ch];
        end
      end
      if (start_evt)                            mode_q <= ZCV_SEED;
      else if (release_evt)                     mode_q <= ZCV_MANUAL;
      else if (seed_run && ((pend_q & ~app) == '0)) mode_q <= ZCV_ACTIVE;
    end
  end
endmodule

// File: rtl/zcv_volume_sva.sv
module zcv_volume_sva #(
  parameter int GAIN_W = 8,
  parameter int TCW    = 11,
  parameter int WCW    = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GAIN_W-1:0] gain_l,
  input logic [GAIN_W-1:0] gain_r,
  input logic [GAIN_W-1:0] tgt_l,
  input logic [GAIN_W-1:0] tgt_r,
  input logic [1:0]        app,
  input logic [1:0]        diff_wr,
  input logic [1:0]        pend,
  input logic              wait_hit,
  input logic              start_evt,
  input logic [TCW-1:0]    tmo_cnt,
  input logic [TCW-1:0]    tmo_lim,
  input logic [WCW-1:0]    wait_cnt,
  input logic [WCW-1:0]    wait_lim
);
  p_gain_l_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_l != $past(gain_l)) |-> $past(app[0] || wait_hit));

  p_gain_r_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_r != $past(gain_r)) |-> $past(app[1] || wait_hit));

  p_apply_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    app[0] |=> !pend[0]);

  p_diff_write_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    diff_wr[0] |=> (pend[0] && gain_l == $past(gain_l)));

  p_tmo_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_cnt < tmo_lim);

  p_wait_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt < wait_lim);

  p_seed_common_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (tgt_l == tgt_r && pend == 2'b11));
endmodule

bind zcv_volume_ctrl zcv_volume_sva #(.GAIN_W(GAIN_W), .TCW(TCW), .WCW(WCW)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .gain_l    (gain_l),
  .gain_r    (gain_r),
  .tgt_l     (tgt_q[0]),
  .tgt_r     (tgt_q[1]),
  .app       (app),
  .diff_wr   (diff_wr),
  .pend      (pend_q),
  .wait_hit  (wait_hit),
  .start_evt (start_evt),
  .tmo_cnt   (tmo_cnt),
  .tmo_lim   (tmo_lim),
  .wait_cnt  (wait_cnt),
  .wait_lim  (wait_lim)
);

// File: tb/zcv_volume_ctrl_tb.sv
`timescale 1ns/1ps
module zcv_volume_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic smp_valid = 1'b0;
  logic [15:0] smp_l = 16'h0100, smp_r = 16'h0100;
  logic lvl_en = 1'b0;
  logic [7:0] lvl_gain_l = '0, lvl_gain_r = '0;
  logic [1:0] tmo_sel = '0, wait_sel = '0;
  logic [7:0] gain_l, gain_r;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  bit model_on = 0;

  localparam logic [15:0] POS = 16'h0100;
  localparam logic [15:0] NEG = 16'h8100;

  always #2.5 clk = ~clk;

  zcv_volume_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .smp_valid(smp_valid), .smp_l(smp_l), .smp_r(smp_r), .lvl_en(lvl_en),
    .lvl_gain_l(lvl_gain_l), .lvl_gain_r(lvl_gain_r), .tmo_sel(tmo_sel),
    .wait_sel(wait_sel), .gain_l(gain_l), .gain_r(gain_r)
  );

  // Bench reference model of manual-mode behaviour
  logic [7:0] m_vol [2];
  logic [7:0] m_gain [2];
  logic       m_pend [2];
  logic       m_prev [2];
  int         m_tcnt;

  function automatic logic crosses(input logic prev_neg, input logic [15:0] s);
    return (s == 16'h0000) || (s[15] != prev_neg);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 2; i++) begin
      m_vol[i] = 8'h91; m_gain[i] = 8'h91; m_pend[i] = 0; m_prev[i] = 0;
    end
    m_tcnt = 0;
  endtask

  task automatic model_step();
    logic [15:0] s [2];
    logic [7:0]  a [2];
    logic zc [2];
    logic df [2];
    logic anyd, anyp, hit;
    int lim;
    s[0] = smp_l; s[1] = smp_r; a[0] = 8'h09; a[1] = 8'h0C;
    lim = 128 << tmo_sel;
    for (int i = 0; i < 2; i++) begin
      zc[i] = smp_valid && crosses(m_prev[i], s[i]);
      df[i] = wr_en && (wr_addr == a[i]) && (wr_data != m_vol[i]);
    end
    anyd = df[0] || df[1];
    anyp = m_pend[0] || m_pend[1];
    hit  = smp_valid && anyp && !anyd && (m_tcnt == lim - 1);
    for (int i = 0; i < 2; i++) begin
      if (df[i]) begin m_vol[i] = wr_data; m_pend[i] = 1; end
      else if (m_pend[i] && (zc[i] || hit)) begin m_gain[i] = m_vol[i]; m_pend[i] = 0; end
    end
    if (anyd || !anyp) m_tcnt = 0;
    else if (smp_valid) m_tcnt = hit ? 0 : m_tcnt + 1;
    if (smp_valid) for (int i = 0; i < 2; i++) m_prev[i] = s[i][15];
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                     input logic v, input logic [15:0] sl, input logic [15:0] sr);
    @(negedge clk);
    wr_en = we; wr_addr = a; wr_data = d; smp_valid = v; smp_l = sl; smp_r = sr;
    if (model_on) model_step();
    @(posedge clk);
    #1;
    wr_en = 1'b0; smp_valid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    cyc(1'b1, a, d, 1'b0, smp_l, smp_r);
  endtask

  task automatic run(input int n, input logic [15:0] sl, input logic [15:0] sr);
    for (int k = 0; k < n; k++) cyc(1'b0, 8'h00, 8'h00, 1'b1, sl, sr);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    logic [7:0] vals [3];
    vals[0] = 8'hC6; vals[1] = 8'hE1; vals[2] = 8'hF1;
    void'($urandom(32'h5EED_0042));

    // ---- Random manual-mode phase against the bench model (R2 R3 R4 R5 R6)
    do_reset();
    model_reset();
    model_on = 1;
    check("R1 gain_l reset", gain_l, 8'h91);
    check("R1 gain_r reset", gain_r, 8'h91);
    for (int n = 0; n < 4000; n++) begin
      logic we, v;
      logic [7:0] a, d;
      logic [15:0] sl, sr;
      int r;
      we = ($urandom % 40) == 0;
      r  = $urandom % 5;
      a  = (r < 2) ? 8'h09 : (r < 4) ? 8'h0C : 8'h0A;
      d  = vals[$urandom % 3];
      v  = ($urandom % 4) != 0;
      r  = $urandom % 48;
      sl = (r == 0) ? 16'h0000 : (r < 3) ? (16'h8000 | 16'($urandom)) : (16'($urandom) & 16'h7FFF) | 16'h0001;
      r  = $urandom % 48;
      sr = (r == 0) ? 16'h0000 : (r < 3) ? (16'h8000 | 16'($urandom)) : (16'($urandom) & 16'h7FFF) | 16'h0001;
      cyc(we, a, d, v, sl, sr);
      check("R2/R5 random gain_l", gain_l, m_gain[0]);
      check("R2/R5 random gain_r", gain_r, m_gain[1]);
    end
    model_on = 0;

    // ---- Directed corner cases
    do_reset();
    smp_l = POS; smp_r = POS;
    check("R1 gain_l after reset", gain_l, 8'h91);
    check("R1 gain_r after reset", gain_r, 8'h91);

    // R2 timeout edge with code 0 (128 samples)
    wr(8'h09, 8'hC6);
    run(127, POS, POS);
    check("R2 before timeout", gain_l, 8'h91);
    run(1, POS, POS);
    check("R2 at timeout", gain_l, 8'hC6);

    // R5 zero crossing on the right channel only
    wr(8'h0C, 8'hE1);
    run(10, POS, POS);
    check("R5 no crossing yet", gain_r, 8'h91);
    run(1, POS, NEG);
    check("R5 right crossing applies", gain_r, 8'hE1);
    check("R5 left untouched", gain_l, 8'hC6);
    run(1, POS, POS);

    // R3 repeated write keeps the running timeout
    wr(8'h09, 8'hE1);
    run(100, POS, POS);
    wr(8'h09, 8'hE1);
    run(27, POS, POS);
    check("R3 before timeout", gain_l, 8'hC6);
    run(1, POS, POS);
    check("R3 timeout not restarted", gain_l, 8'hE1);

    // R4 differing write restarts the timeout
    wr(8'h09, 8'hF1);
    run(100, POS, POS);
    wr(8'h09, 8'hC6);
    run(127, POS, POS);
    check("R4 restarted, not yet", gain_l, 8'hE1);
    run(1, POS, POS);
    check("R4 applied after restart", gain_l, 8'hC6);

    // R4 fast differing writes starve the update
    for (int k = 0; k < 4; k++) begin
      wr(8'h09, (k % 2 == 0) ? 8'hF1 : 8'hE1);
      run(120, POS, POS);
    end
    check("R4 starved", gain_l, 8'hC6);
    run(8, POS, POS);
    check("R4 settles to last", gain_l, 8'hE1);

    // R6 other address ignored
    wr(8'h0A, 8'h11);
    run(130, POS, POS);
    check("R6 foreign address left", gain_l, 8'hE1);
    check("R6 foreign address right", gain_r, 8'hE1);

    // R8 seed from left register
    wr(8'h09, 8'hC6);
    run(128, POS, POS);
    check("R8 setup left", gain_l, 8'hC6);
    lvl_gain_l = 8'h80; lvl_gain_r = 8'h70;
    @(negedge clk); lvl_en = 1'b1;
    @(posedge clk); #1;
    run(127, POS, POS);
    check("R8 seed pending right", gain_r, 8'hE1);
    run(1, POS, POS);
    check("R8 seed left", gain_l, 8'hC6);
    check("R8 seed right from left", gain_r, 8'hC6);

    // R7 writes frozen, R9 level gains after the wait period (32 samples)
    wr(8'h09, 8'hF1);
    wr(8'h0C, 8'hA0);
    run(31, POS, NEG);
    check("R7 frozen left", gain_l, 8'hC6);
    check("R7 frozen right", gain_r, 8'hC6);
    run(1, POS, NEG);
    check("R9 level gain left", gain_l, 8'h80);
    check("R9 level gain right", gain_r, 8'h70);
    run(1, POS, POS);

    // R10 release replays stored writes at the crossing
    @(negedge clk); lvl_en = 1'b0;
    @(posedge clk); #1;
    run(5, POS, POS);
    check("R10 held before crossing", gain_l, 8'h80);
    run(1, NEG, NEG);
    check("R10 replay left", gain_l, 8'hF1);
    check("R10 replay right", gain_r, 8'hA0);

    // R6 longest timeout code 3 (1024 samples)
    run(1, POS, POS);
    tmo_sel = 2'd3;
    wr(8'h09, 8'hC6);
    run(1023, POS, POS);
    check("R6 code 3 before", gain_l, 8'hF1);
    run(1, POS, POS);
    check("R6 code 3 at limit", gain_l, 8'hC6);

    done = 1;
    summary();
  end
endmodule